// File: doc/BRIEF.md
# PWM Phase Doubler

This block sits between one PWM output of a multiphase controller and two power-stage inputs. It turns one PWM stream into two phase drives. In the two interleaving modes, it steers successive input pulses to channel A and channel B in turn, so each channel runs at half the controller rate. In synchronous mode, it copies each pulse to both channels with no skew between them. Each channel's turn-off is stretched by an extension counted in clock cycles. A per-pulse trim input sets the variable part of that extension, and the second interleaving mode adds a fixed part.

All levels are digital codes. An external level decoder supplies the input PWM level and the mode code. When the block is disabled, it asks the controller side to hold the shared PWM line high, so the controller can shed this phase. After it is enabled again, the block stays idle with both outputs tri-state until the first rising edge of the input. A fault flag can force the outputs active during that wait. An input parked at the mid level for longer than a holdoff time sends both outputs to tri-state. A mode is always adopted at an input rising edge, so a pulse already in progress is never truncated.

Top module: `pd_phase_doubler`

## Requirements
- R1: Level codes are as follows. Input PWM: 00 is low, 01 is high, and 1x is mid. Outputs: 00 is low, 01 is high, and 10 is tri-state. In either interleaving mode, each input rising edge starts a high pulse on exactly one output, and the target alternates A, B, A, and so on. The output stays high for the input high time plus the extension.
- R2: In synchronous mode (mode code 10), every input pulse drives both outputs high for the same number of cycles. The toggle state is left unchanged.
- R3: While `enable` is low, both outputs are tri-state and `force_high` is 1. Any pulse in progress is dropped, and the toggle state returns to channel A.
- R4: Once `enable` is high, both outputs stay tri-state until the first input rising edge. That edge starts a pulse on channel A.
- R5: Before that first rising edge, `fault` = 1 drives both outputs low instead of tri-state.
- R6: An input held at the mid level for HOLDOFF_CYC (13) consecutive synchronized cycles puts both outputs in tri-state. Before that point the outputs show their normal low or high level. The next rising edge resumes operation.
- R7: The extension is min(`trim`, TRIM_MAX = 14) cycles. In interleaving mode 2 (mode code 01), FIXED_EXT_CYC (24) more cycles are added. `trim` is sampled when the input falls.
- R8: Interleaving mode 2 is adopted only at the fourth consecutive input rising edge that sees mode code 01. That fourth pulse already uses the longer extension.
- R9: Mode codes 00 (interleaving 1) and 10 (synchronous) take effect at the very next rising edge. Code 11 is ignored: the mode in force is kept, but the mode-2 qualification count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_code | input | 2 | Input PWM level code (asynchronous, synchronized inside) |
| mode_code | input | 2 | Mode code from the level decoder |
| enable | input | 1 | Doubler enable |
| fault | input | 1 | Overcurrent fault flag |
| trim | input | 4 | Variable extension in cycles |
| out_a | output | 2 | Channel A level code |
| out_b | output | 2 | Channel B level code |
| force_high | output | 1 | Request to hold the shared PWM line high |

## Verification
The bench measures each output pulse as a count of high cycles and compares it with a model built only from the requirements. An extension that is off by one cycle, a trim that is not clamped, or a channel that is picked wrongly each shows up as a count mismatch.

The mode-2 qualification is tested with a sequence of three mode-2 codes, then a reserved code, then four more mode-2 codes. A design that counts cycles instead of edges, or that lets the reserved code keep the streak alive, would stretch the wrong pulse.

The mid-level holdoff is checked on both sides of its threshold, so tri-state entered too early or too late is caught. Re-enabling is checked for the fault override and for a restart on channel A, which catches a toggle state that survives a disable.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam logic [1:0] LV_LOW  = 2'b00;
  localparam logic [1:0] LV_HIGH = 2'b01;
  localparam logic [1:0] LV_TRI  = 2'b10;

  typedef enum logic [1:0] {
    MD_IL1  = 2'b00,
    MD_IL2  = 2'b01,
    MD_SYNC = 2'b10,
    MD_RSV  = 2'b11
  } mode_t;
endpackage

// File: rtl/pd_edge_unit.sv
module pd_edge_unit #(
  parameter int HOLDOFF_CYC = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_raw,
  output logic       rise,
  output logic       fall,
  output logic       tri_hold
);
  import pd_pkg::*;
  localparam int HW = $clog2(HOLDOFF_CYC + 1);

  logic [1:0]    s1_q, s2_q, prev_q;
  logic [HW-1:0] hold_q;
  logic          mid_now;

  assign mid_now  = s2_q[1];
  assign rise     = (s2_q == LV_HIGH) && (prev_q != LV_HIGH);
  assign fall     = (prev_q == LV_HIGH) && (s2_q != LV_HIGH);
  assign tri_hold = (hold_q >= HW'(HOLDOFF_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= LV_LOW;
      s2_q   <= LV_LOW;
      prev_q <= LV_LOW;
      hold_q <= '0;
    end else begin
      s1_q   <= pwm_raw;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (!mid_now)
        hold_q <= '0;
      else if (hold_q != HW'(HOLDOFF_CYC))
        hold_q <= hold_q + HW'(1);
    end
  end

  // R6: tri-state hold can only follow a mid-level sample
  a_r6_hold_after_mid: assert property (@(posedge clk) disable iff (!rst_n)
    tri_hold |-> $past(mid_now));
endmodule

// File: rtl/pd_mode_qual.sv
module pd_mode_qual #(
  parameter int QUAL_PULSES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic [1:0]    mode_code,
  output pd_pkg::mode_t mode_q,
  output pd_pkg::mode_t mode_now
);
  import pd_pkg::*;
  localparam int QW = $clog2(QUAL_PULSES + 1);

  mode_t         code, cand_q, mode_n;
  logic [QW-1:0] streak_q, streak_n;

  assign code = mode_t'(mode_code);

  always_comb begin
    if (code != cand_q)
      streak_n = QW'(1);
    else if (streak_q == QW'(QUAL_PULSES))
      streak_n = streak_q;
    else
      streak_n = streak_q + QW'(1);

    mode_n = mode_q;
    if (rise) begin
      case (code)
        MD_IL1, MD_SYNC: mode_n = code;
        MD_IL2:          if (streak_n >= QW'(QUAL_PULSES)) mode_n = MD_IL2;
        default:         mode_n = mode_q;
      endcase
    end
  end

  assign mode_now = mode_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q   <= MD_IL1;
      streak_q <= '0;
      mode_q   <= MD_IL1;
    end else if (rise) begin
      cand_q   <= code;
      streak_q <= streak_n;
      mode_q   <= mode_n;
    end
  end

  // R8: mode 2 is entered only on a rise that completes the streak
  a_r8_il2_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_IL2 && $past(mode_q) != MD_IL2)
      |-> $past(rise && code == MD_IL2 && streak_q >= QW'(QUAL_PULSES - 1)));
  // R9: the reserved code leaves the mode untouched
  a_r9_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && code == MD_RSV) |=> mode_q == $past(mode_q));
endmodule

// File: rtl/pd_channel.sv
module pd_channel #(
  parameter int EXT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             start,
  input  logic             fall,
  input  logic [EXT_W-1:0] ext_len,
  output logic             hi
);
  logic             hi_q, run_q;
  logic [EXT_W-1:0] cnt_q;

  assign hi = hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (kill) begin
      hi_q  <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      hi_q  <= 1'b1;
      run_q <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == EXT_W'(1)) begin
        hi_q  <= 1'b0;
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - EXT_W'(1);
      end
    end else if (hi_q && fall) begin
      if (ext_len == '0)
        hi_q <= 1'b0;
      else begin
        run_q <= 1'b1;
        cnt_q <= ext_len;
      end
    end
  end

  // R7: an extension in progress keeps the output high
  a_r7_ext_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q > EXT_W'(1) && !kill) |=> hi_q);
  // R7: a running extension never holds a zero count
  a_r7_ext_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q != '0);
endmodule

// File: rtl/pd_phase_doubler.sv
module pd_phase_doubler #(
  parameter int HOLDOFF_CYC   = 13,
  parameter int FIXED_EXT_CYC = 24,
  parameter int TRIM_W        = 4,
  parameter int TRIM_MAX      = 14,
  parameter int QUAL_PULSES   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pwm_code,
  input  logic [1:0]        mode_code,
  input  logic              enable,
  input  logic              fault,
  input  logic [TRIM_W-1:0] trim,
  output logic [1:0]        out_a,
  output logic [1:0]        out_b,
  output logic              force_high
);
  import pd_pkg::*;
  localparam int EXT_W = $clog2(TRIM_MAX + FIXED_EXT_CYC + 1);
  localparam int NCH   = 2;

  logic             rise, fall, tri_hold;
  mode_t            mode_q, mode_now;
  logic             armed_q, tog_q, start_any, il_now;
  logic [NCH-1:0]   start_vec, hi;
  logic [EXT_W-1:0] trim_x, trim_cl, ext_len;
  logic [1:0]       lvl [NCH];

  pd_edge_unit #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_edge (
    .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_code),
    .rise(rise), .fall(fall), .tri_hold(tri_hold));

  pd_mode_qual #(.QUAL_PULSES(QUAL_PULSES)) u_mode (
    .clk(clk), .rst_n(rst_n), .rise(rise), .mode_code(mode_code),
    .mode_q(mode_q), .mode_now(mode_now));

  assign start_any = enable && rise;
  assign il_now    = (mode_now != MD_SYNC);
  assign start_vec[0] = start_any && (!il_now || !tog_q);
  assign start_vec[1] = start_any && (!il_now ||  tog_q);

  assign trim_x  = EXT_W'(trim);
  assign trim_cl = (trim_x > EXT_W'(TRIM_MAX)) ? EXT_W'(TRIM_MAX) : trim_x;
  assign ext_len = trim_cl + ((mode_q == MD_IL2) ? EXT_W'(FIXED_EXT_CYC) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tog_q   <= 1'b0;
    end else if (!enable) begin
      armed_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      if (rise) armed_q <= 1'b1;
      if (start_any && il_now) tog_q <= ~tog_q;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pd_channel #(.EXT_W(EXT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .kill(!enable), .start(start_vec[g]),
      .fall(fall), .ext_len(ext_len), .hi(hi[g]));

    always_comb begin
      if (!enable)       lvl[g] = LV_TRI;
      else if (!armed_q) lvl[g] = fault ? LV_LOW : LV_TRI;
      else if (tri_hold) lvl[g] = LV_TRI;
      else               lvl[g] = hi[g] ? LV_HIGH : LV_LOW;
    end
  end

  assign out_a      = lvl[0];
  assign out_b      = lvl[1];
  assign force_high = !enable;

  // R1: an interleaved pulse from an idle pair lights exactly one channel
  a_r1_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (start_any && il_now && hi == '0) |=> hi[0] != hi[1]);
  // R2: a synchronous pulse lights both channels
  a_r2_both_channels: assert property (@(posedge clk) disable iff (!rst_n)
    (start_any && !il_now) |=> (hi[0] && hi[1]));
  // R3: disabling drops both channels
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> hi == '0);
  // R4: arming only follows an input rising edge
  a_r4_arm_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(rise));
endmodule

// File: tb/sim_pd_phase_doubler.sv
module sim_pd_phase_doubler;
  localparam int HOLD = 13;
  localparam int FIX  = 24;
  localparam int TMAX = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwm = 2'b00;
  logic [1:0] mcode = 2'b00;
  logic       en = 1'b0;
  logic       flt = 1'b0;
  logic [3:0] trim = 4'd0;
  logic [1:0] out_a, out_b;
  logic       force_high;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  // bench model state
  int b_mode = 0, b_cand = 0, b_streak = 0, b_tog = 0;

  always #2.5 clk = ~clk;

  pd_phase_doubler u0 (
    .clk(clk), .rst_n(rst_n), .pwm_code(pwm), .mode_code(mcode),
    .enable(en), .fault(flt), .trim(trim),
    .out_a(out_a), .out_b(out_b), .force_high(force_high));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic int exp_ext(input int m, input int t);
    int v;
    v = (t > TMAX) ? TMAX : t;
    if (m == 1) v += FIX;
    return v;
  endfunction

  // R8/R9 qualification model applied at each input rising edge
  task automatic model_rise(input int c);
    if (c == b_cand) begin
      if (b_streak < 4) b_streak++;
    end else begin
      b_cand = c;
      b_streak = 1;
    end
    if (c == 0 || c == 2) b_mode = c;
    else if (c == 1 && b_streak >= 4) b_mode = 1;
  endtask

  task automatic pulse(input int c, input int w, input int t, input string req);
    int ca = 0, cb = 0, e, expa, expb;
    mcode = 2'(c);
    trim = 4'(t);
    model_rise(c);
    e = exp_ext(b_mode, t);
    if (b_mode == 2) begin
      expa = w + e; expb = w + e;
    end else begin
      expa = (b_tog == 0) ? w + e : 0;
      expb = (b_tog == 1) ? w + e : 0;
      b_tog ^= 1;
    end
    for (int i = 0; i < w + 50; i++) begin
      @(negedge clk);
      if (out_a == 2'b01) ca++;
      if (out_b == 2'b01) cb++;
      pwm = (i < w) ? 2'b01 : 2'b00;
    end
    chk(ca == expa, {req, " chA"}, ca, expa);
    chk(cb == expb, {req, " chB"}, cb, expb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R3 reset state with enable low
    chk(out_a == 2'b10, "R3 reset outA", out_a, 2);
    chk(out_b == 2'b10, "R3 reset outB", out_b, 2);
    chk(force_high == 1'b1, "R3 force_high", force_high, 1);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    repeat (4) @(negedge clk);
    // R4 idle until first edge
    chk(out_a == 2'b10 && out_b == 2'b10, "R4 idle tri", out_a, 2);
    chk(force_high == 1'b0, "R4 force_high low", force_high, 0);
    // R5 fault before arming
    flt = 1'b1;
    @(negedge clk);
    chk(out_a == 2'b00 && out_b == 2'b00, "R5 fault low", out_a, 0);
    flt = 1'b0;
    @(negedge clk);
    chk(out_a == 2'b10, "R4 tri after fault", out_a, 2);
    // R4 first pulse on A, R1 interleave
    pulse(0, 6, 0, "R4 first pulse");
    for (int k = 0; k < 8; k++)
      pulse(0, 3 + int'($urandom_range(17)), int'($urandom_range(13)), "R1 interleave");
    // R7 trim clamp
    pulse(0, 5, 15, "R7 trim clamp");
    // R8 and R9: reserved breaks the streak
    for (int k = 0; k < 3; k++) pulse(1, 4 + k, 3, "R8 pre-qual");
    pulse(3, 5, 2, "R9 reserved in il1");
    for (int k = 0; k < 3; k++) pulse(1, 6, 5, "R8 streak restart");
    pulse(1, 7, 9, "R8 fourth edge");
    for (int k = 0; k < 2; k++)
      pulse(1, 3 + int'($urandom_range(10)), int'($urandom_range(15)), "R7 il2 ext");
    pulse(0, 8, 4, "R9 back to il1");
    // R2 synchronous
    for (int k = 0; k < 3; k++)
      pulse(2, 3 + int'($urandom_range(15)), int'($urandom_range(15)), "R2 sync");
    pulse(3, 6, 6, "R9 reserved in sync");
    pulse(0, 5, 1, "R1 toggle kept over sync");
    // R6 mid-level holdoff
    @(negedge clk);
    pwm = 2'b10;
    for (int j = 1; j <= HOLD + 3; j++) begin
      @(negedge clk);
      if (j == HOLD)
        chk(out_a == 2'b00 && out_b == 2'b00, "R6 before holdoff", out_a, 0);
      if (j == HOLD + 3) begin
        chk(out_a == 2'b10, "R6 tri A", out_a, 2);
        chk(out_b == 2'b10, "R6 tri B", out_b, 2);
      end
    end
    pulse(0, 6, 2, "R6 resume");
    // R3 disable mid stream
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(out_a == 2'b10 && out_b == 2'b10, "R3 disabled tri", out_a, 2);
    chk(force_high == 1'b1, "R3 request high", force_high, 1);
    b_tog = 0;
    @(negedge clk);
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_b == 2'b10, "R4 re-enable tri", out_b, 2);
    pulse(0, 7, 3, "R3 restart on A");
    // mixed random tail
    for (int k = 0; k < 20; k++) begin
      int c;
      c = int'($urandom_range(3));
      pulse(c, 3 + int'($urandom_range(20)), int'($urandom_range(15)), "R9 random mix");
    end
    report();
  end
endmodule